// File: doc/BRIEF.md
# Companion Lookup-RAM Access Event Detector

This block sits beside a core's 512-entry lookup RAM and watches the read and write strobes that the paired companion core drives into that RAM. One of the four highest locations can be chosen as a watch point. When the companion core touches that location in the selected way, the block sets a sticky event flag. The local core either polls the flag, which clears it, or waits on it. A wait stalls the local core until the flag is set, then lets it go and clears the flag in the same step.

Setup goes through a shared event-configuration port that serves several event slots. A strobe carries a slot number and a packed select code. This block takes the code only when the slot number is its own. Bits 1..0 of the code pick the watched address as the top-four base plus that value. Bits 3..2 pick the kind of access to watch. Any set bit above bit 3 marks a code that belongs to another event group, and this block then treats the event as disabled. Every accepted setup discards any pending event.

Top module: `lut_evt_detect`

## Requirements
- R1: After reset the flag is 0 and the event is disabled, so companion accesses to any address leave the flag at 0 until a setup is accepted.
- R2: A setup strobe is accepted only when `cfg_slot` equals the block's slot number (default 0). A strobe for another slot changes neither the watched address, nor the mode, nor the flag.
- R3: An accepted code with any bit set from bit 4 upward disables the event, whatever bits 3..0 hold.
- R4: The watched address is 0x1FC plus code bits 1..0. An access to any other 9-bit address never sets the flag, and this includes addresses that share the low two bits with the watched one.
- R5: Code bits 3..2 select the mode. 00 means disabled. 01 means a companion read or write. 10 means a companion read only. 11 means a companion write only.
- R6: A matching access sets `evt_flag` from the next cycle on. The flag then stays set until a poll, a wait release or a setup clears it.
- R7: A poll strobe while the flag is set clears it in the next cycle. If a matching access arrives in the same cycle as the poll, the flag stays set.
- R8: `wait_stall` is high while `wait_req` is high and the flag is 0. In a cycle with `wait_req` high and the flag set, `wait_release` is high and the flag is 0 in the next cycle, unless a new match arrives in that same cycle.
- R9: An accepted setup clears the flag in the next cycle. This holds even when a matching access arrives in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_stb | input | 1 | Setup strobe on the shared event-configuration port |
| cfg_slot | input | 2 | Event slot number that the strobe addresses |
| cfg_code | input | 8 | Packed select code: [1:0] address offset, [3:2] mode, [7:4] must be zero |
| cmp_rd | input | 1 | Companion core reads the lookup RAM this cycle |
| cmp_wr | input | 1 | Companion core writes the lookup RAM this cycle |
| cmp_addr | input | 9 | Lookup RAM address of the companion access |
| poll_stb | input | 1 | Local core polls the flag and clears it |
| wait_req | input | 1 | Local core is waiting on the event |
| evt_flag | output | 1 | Sticky event flag |
| wait_stall | output | 1 | Local core must stay stalled this cycle |
| wait_release | output | 1 | Wait completes this cycle, and the flag clears |

## Verification
The collisions are the hardest cases to reach from the ports. These are a match that lands in the same cycle as a poll, as a wait release, or as a setup strobe, where each case has a different winner. The stimulus first arms the flag with a single matching access. It then drives the clearing input and a fresh match on the very same clock, and samples the flag one cycle later. Near misses are also covered: addresses with the same low bits, the wrong access direction, and foreign slots or foreign code groups.

// File: rtl/lut_evt_pkg.sv
package lut_evt_pkg;
  localparam int LUT_SEL_W  = 2;
  localparam int LUT_MODE_W = 2;
  localparam int LUT_FIELD_W = LUT_SEL_W + LUT_MODE_W;

  typedef enum logic [LUT_MODE_W-1:0] {
    EVM_OFF = 2'b00,
    EVM_ANY = 2'b01,
    EVM_RD  = 2'b10,
    EVM_WR  = 2'b11
  } evt_mode_e;

  typedef struct packed {
    evt_mode_e            mode;
    logic [LUT_SEL_W-1:0] sel;
  } evt_cfg_t;
endpackage

// File: rtl/lut_evt_cfg.sv
module lut_evt_cfg
  import lut_evt_pkg::*;
#(
  parameter int CODE_W  = 8,
  parameter int SLOT_W  = 2,
  parameter int MY_SLOT = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_stb,
  input  logic [SLOT_W-1:0] cfg_slot,
  input  logic [CODE_W-1:0] cfg_code,
  output evt_cfg_t          cfg_q,
  output logic              cfg_load
);
  localparam logic [SLOT_W-1:0] SLOT_ID = SLOT_W'(MY_SLOT);

  logic     group_ok;
  evt_cfg_t cfg_d;

  assign cfg_load = cfg_stb && (cfg_slot == SLOT_ID);

  generate
    if (CODE_W > LUT_FIELD_W) begin : g_grp
      assign group_ok = (cfg_code[CODE_W-1:LUT_FIELD_W] == '0);
    end else begin : g_nogrp
      assign group_ok = 1'b1;
    end
  endgenerate

  always_comb begin
    cfg_d.sel  = cfg_code[LUT_SEL_W-1:0];
    cfg_d.mode = group_ok ? evt_mode_e'(cfg_code[LUT_FIELD_W-1:LUT_SEL_W]) : EVM_OFF;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= '{mode: EVM_OFF, sel: '0};
    end else if (cfg_load) begin
      cfg_q <= cfg_d;
    end
  end

  AST_FOREIGN_SLOT_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_stb && cfg_slot != SLOT_ID) |=> $stable(cfg_q)); // R2

  AST_FOREIGN_GROUP_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_load && !group_ok) |=> (cfg_q.mode == EVM_OFF)); // R3
endmodule

// File: rtl/lut_evt_match.sv
module lut_evt_match
  import lut_evt_pkg::*;
#(
  parameter int ADDR_W = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  evt_cfg_t          cfg_q,
  input  logic              cmp_rd,
  input  logic              cmp_wr,
  input  logic [ADDR_W-1:0] cmp_addr,
  output logic              hit
);
  localparam int NUM_WATCH  = 1 << LUT_SEL_W;
  localparam int WATCH_BASE = (1 << ADDR_W) - NUM_WATCH;

  logic [NUM_WATCH-1:0] at_watch;
  logic                 addr_hit;
  logic                 kind_ok;

  genvar gi;
  generate
    for (gi = 0; gi < NUM_WATCH; gi++) begin : g_watch
      localparam logic [ADDR_W-1:0] WADDR = ADDR_W'(WATCH_BASE + gi);
      assign at_watch[gi] = (cmp_addr == WADDR);
    end
  endgenerate

  assign addr_hit = at_watch[cfg_q.sel];

  always_comb begin
    unique case (cfg_q.mode)
      EVM_ANY: kind_ok = cmp_rd || cmp_wr;
      EVM_RD:  kind_ok = cmp_rd;
      EVM_WR:  kind_ok = cmp_wr;
      default: kind_ok = 1'b0;
    endcase
  end

  assign hit = addr_hit && kind_ok;

  AST_OFF_NO_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_q.mode == EVM_OFF) |-> !hit); // R5

  AST_HIT_IN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> ($countones(at_watch) == 1)); // R4
endmodule

// File: rtl/lut_evt_flag.sv
module lut_evt_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic hit,
  input  logic cfg_load,
  input  logic poll_stb,
  input  logic wait_req,
  output logic evt_flag,
  output logic wait_stall,
  output logic wait_release
);
  logic ack;

  assign wait_stall   = wait_req && !evt_flag;
  assign wait_release = wait_req && evt_flag;
  assign ack          = poll_stb || wait_release;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      evt_flag <= 1'b0;
    end else if (cfg_load) begin
      evt_flag <= 1'b0;
    end else if (hit) begin
      evt_flag <= 1'b1;
    end else if (ack) begin
      evt_flag <= 1'b0;
    end
  end

  AST_HIT_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && !cfg_load) |=> evt_flag); // R6

  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_flag && !poll_stb && !wait_req && !cfg_load) |=> evt_flag); // R6

  AST_POLL_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (poll_stb && !hit && !cfg_load) |=> !evt_flag); // R7

  AST_RELEASE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (wait_release && !hit) |=> !evt_flag); // R8

  AST_CFG_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_load |=> !evt_flag); // R9
endmodule

// File: rtl/lut_evt_detect.sv
module lut_evt_detect
  import lut_evt_pkg::*;
#(
  parameter int ADDR_W  = 9,
  parameter int CODE_W  = 8,
  parameter int SLOT_W  = 2,
  parameter int MY_SLOT = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_stb,
  input  logic [SLOT_W-1:0] cfg_slot,
  input  logic [CODE_W-1:0] cfg_code,
  input  logic              cmp_rd,
  input  logic              cmp_wr,
  input  logic [ADDR_W-1:0] cmp_addr,
  input  logic              poll_stb,
  input  logic              wait_req,
  output logic              evt_flag,
  output logic              wait_stall,
  output logic              wait_release
);
  evt_cfg_t cfg_q;
  logic     cfg_load;
  logic     hit;

  lut_evt_cfg #(.CODE_W(CODE_W), .SLOT_W(SLOT_W), .MY_SLOT(MY_SLOT)) u_cfg (
    .clk(clk), .rst_n(rst_n), .cfg_stb(cfg_stb), .cfg_slot(cfg_slot),
    .cfg_code(cfg_code), .cfg_q(cfg_q), .cfg_load(cfg_load)
  );

  lut_evt_match #(.ADDR_W(ADDR_W)) u_match (
    .clk(clk), .rst_n(rst_n), .cfg_q(cfg_q), .cmp_rd(cmp_rd),
    .cmp_wr(cmp_wr), .cmp_addr(cmp_addr), .hit(hit)
  );

  lut_evt_flag u_flag (
    .clk(clk), .rst_n(rst_n), .hit(hit), .cfg_load(cfg_load),
    .poll_stb(poll_stb), .wait_req(wait_req), .evt_flag(evt_flag),
    .wait_stall(wait_stall), .wait_release(wait_release)
  );

  AST_NO_STALL_AND_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    !(wait_stall && wait_release)); // R8
endmodule

// File: tb/lut_evt_detect_bench.sv
module lut_evt_detect_bench;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_stb = 1'b0;
  logic [1:0] cfg_slot = '0;
  logic [7:0] cfg_code = '0;
  logic cmp_rd = 1'b0, cmp_wr = 1'b0;
  logic [8:0] cmp_addr = '0;
  logic poll_stb = 1'b0, wait_req = 1'b0;
  logic evt_flag, wait_stall, wait_release;

  always #(CLK_PERIOD/2) clk = ~clk;

  lut_evt_detect u_lut_evt_detect (
    .clk(clk), .rst_n(rst_n), .cfg_stb(cfg_stb), .cfg_slot(cfg_slot),
    .cfg_code(cfg_code), .cmp_rd(cmp_rd), .cmp_wr(cmp_wr), .cmp_addr(cmp_addr),
    .poll_stb(poll_stb), .wait_req(wait_req), .evt_flag(evt_flag),
    .wait_stall(wait_stall), .wait_release(wait_release)
  );

  typedef struct {
    logic  flag;
    logic  stall;
    logic  rel;
    string tag;
  } exp_t;

  exp_t exp_q[$];
  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;

  // reference state, derived from the requirements
  logic       m_flag = 1'b0;
  logic [1:0] m_mode = 2'b00;
  logic [1:0] m_sel  = 2'b00;

  task automatic step(input logic rd, input logic wr, input logic [8:0] addr,
                      input logic poll, input logic wt, input logic stb,
                      input logic [1:0] slot, input logic [7:0] code, input string tag);
    exp_t e;
    logic hitm;
    @(negedge clk);
    cmp_rd = rd; cmp_wr = wr; cmp_addr = addr; poll_stb = poll; wait_req = wt;
    cfg_stb = stb; cfg_slot = slot; cfg_code = code;
    e.flag = m_flag; e.stall = wt && !m_flag; e.rel = wt && m_flag; e.tag = tag;
    exp_q.push_back(e);
    hitm = (addr == 9'h1FC + {7'd0, m_sel}) &&
           ((m_mode == 2'b01 && (rd || wr)) || (m_mode == 2'b10 && rd) ||
            (m_mode == 2'b11 && wr));
    if (stb && slot == 2'd0) begin
      m_flag = 1'b0;
      m_sel  = code[1:0];
      m_mode = (code[7:4] == 4'd0) ? code[3:2] : 2'b00;
    end else if (hitm) m_flag = 1'b1;
    else if (poll || (wt && m_flag)) m_flag = 1'b0;
  endtask

  task automatic idle(input string tag);
    step(0, 0, 9'h000, 0, 0, 0, 2'd0, 8'h00, tag);
  endtask
  task automatic cfg(input logic [1:0] slot, input logic [7:0] code, input string tag);
    step(0, 0, 9'h000, 0, 0, 1, slot, code, tag);
  endtask
  task automatic acc(input logic rd, input logic wr, input logic [8:0] a, input string tag);
    step(rd, wr, a, 0, 0, 0, 2'd0, 8'h00, tag);
  endtask

  // monitor: compares each cycle's outputs just before the rising edge
  initial begin
    forever begin
      @(negedge clk);
      #3;
      if (exp_q.size() > 0) begin
        exp_t e;
        e = exp_q.pop_front();
        n_cmp++;
        if (evt_flag !== e.flag || wait_stall !== e.stall || wait_release !== e.rel) begin
          n_bad++;
          $display("FAIL %s: flag/stall/release actual %b%b%b expected %b%b%b",
                   e.tag, evt_flag, wait_stall, wait_release, e.flag, e.stall, e.rel);
        end
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    n_cmp++;
    if (evt_flag !== 1'b0 || wait_stall !== 1'b0 || wait_release !== 1'b0) begin
      n_bad++;
      $display("FAIL R1 reset: actual %b%b%b expected 000", evt_flag, wait_stall, wait_release);
    end
    rst_n = 1'b1;
    // R1: disabled after reset
    acc(0, 1, 9'h1FC, "R1"); acc(1, 1, 9'h1FF, "R1"); idle("R1");
    // R2: foreign slot ignored
    cfg(2'd1, 8'h0F, "R2"); acc(0, 1, 9'h1FF, "R2"); idle("R2");
    // R3: foreign group disables
    cfg(2'd0, 8'h1F, "R3"); acc(0, 1, 9'h1FF, "R3"); acc(1, 1, 9'h1FF, "R3"); idle("R3");
    // R4/R5: write mode at 0x1FD
    cfg(2'd0, 8'h0D, "R4"); acc(0, 1, 9'h1FC, "R4"); acc(0, 1, 9'h0FD, "R4");
    acc(1, 0, 9'h1FD, "R5"); idle("R5");
    acc(0, 1, 9'h1FD, "R6"); idle("R6"); idle("R6"); idle("R6");
    // R2 again: foreign slot leaves pending flag
    cfg(2'd2, 8'h00, "R2"); idle("R2");
    // R7: poll clears, and poll colliding with a match keeps it set
    step(0, 0, 9'h000, 1, 0, 0, 2'd0, 8'h00, "R7"); idle("R7");
    acc(0, 1, 9'h1FD, "R7"); step(0, 1, 9'h1FD, 1, 0, 0, 2'd0, 8'h00, "R7"); idle("R7");
    step(0, 0, 9'h000, 1, 0, 0, 2'd0, 8'h00, "R7"); idle("R7");
    // R8: wait stalls, then releases
    step(0, 0, 9'h000, 0, 1, 0, 2'd0, 8'h00, "R8");
    step(0, 0, 9'h000, 0, 1, 0, 2'd0, 8'h00, "R8");
    step(0, 1, 9'h1FD, 0, 1, 0, 2'd0, 8'h00, "R8");
    step(0, 0, 9'h000, 0, 1, 0, 2'd0, 8'h00, "R8");
    idle("R8");
    // R8: release colliding with a match keeps the flag
    acc(0, 1, 9'h1FD, "R8"); step(0, 1, 9'h1FD, 0, 1, 0, 2'd0, 8'h00, "R8"); idle("R8");
    // R9: setup clears, even with a colliding match
    cfg(2'd0, 8'h0D, "R9"); idle("R9");
    acc(0, 1, 9'h1FD, "R9"); step(0, 1, 9'h1FD, 0, 0, 1, 2'd0, 8'h0D, "R9"); idle("R9");
    // R5: read-only at 0x1FF
    cfg(2'd0, 8'h0B, "R5"); acc(0, 1, 9'h1FF, "R5"); acc(1, 0, 9'h0FF, "R4");
    acc(1, 0, 9'h1FF, "R5"); idle("R5");
    // R5: any-access at 0x1FC
    cfg(2'd0, 8'h04, "R5"); acc(1, 0, 9'h1FC, "R5"); idle("R5");
    step(0, 0, 9'h000, 1, 0, 0, 2'd0, 8'h00, "R5"); acc(0, 1, 9'h1FC, "R5"); idle("R5");
    acc(0, 0, 9'h1FC, "R5"); idle("R5");
    // R5: mode 00 disables
    cfg(2'd0, 8'h03, "R5"); acc(1, 1, 9'h1FF, "R5"); acc(1, 1, 9'h1FC, "R5"); idle("R5");
    idle("end"); idle("end");
    @(negedge clk); #5;
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule